// File: doc/BRIEF.md
# Truncating float-to-integer converter

This block turns a 32-bit IEEE single-precision operand into a 32-bit integer, dropping any fractional part so that the result moves toward zero. A mode input picks a two's-complement signed result or a plain unsigned result. The operand layout is fixed by the format: bit 31 is the sign, bits 30:23 hold the biased exponent (bias 127), and bits 22:0 hold the fraction.

A conversion starts when `start_i` is high at a rising clock edge. On that edge the converter latches the integer and two flags into output registers, and `done_o` is high for exactly the following cycle. Between conversions the outputs keep their last values and the operand input is ignored.

Two flags describe the outcome. `invalid_o` reports a result that cannot be represented: a NaN, a value out of range, or a negative value in unsigned mode. `inexact_o` reports that fraction bits were thrown away. The two flags are never set together.

Top module: `f2i_trunc`

## Requirements
- R1: An in-range finite operand gives its value truncated toward zero. For example, 2.75 gives 2, -2.75 gives 0xFFFFFFFE in signed mode, and 0.5 gives 0. `unsigned_i`=0 selects signed mode and `unsigned_i`=1 selects unsigned mode.
- R2: Any NaN (exponent field all ones, fraction nonzero), of either sign and in either mode, gives result 0 with `invalid_o`=1 and `inexact_o`=0.
- R3: `invalid_o` and `inexact_o` are never high at the same time. Raising invalid suppresses inexact.
- R4: In unsigned mode, an operand that is negative, not a NaN and not zero gives 0 with only `invalid_o` set. This includes negative fractions, negative denormals and negative infinity. Negative zero gives 0 with no flags.
- R5: In signed mode, a value at or above 2^31 (including +infinity) gives 0x7FFFFFFF with `invalid_o`. A value below -2^31 (including -infinity) gives 0x80000000 with `invalid_o`. Exactly -2^31 gives 0x80000000 with no flags.
- R6: In unsigned mode, a non-negative value at or above 2^32 (including +infinity) gives 0xFFFFFFFF with `invalid_o`. Values up to the largest float below 2^32 convert exactly.
- R7: `inexact_o` is 1 exactly when the result is in range and nonzero fraction bits were discarded. An integral operand raises no flag.
- R8: A denormal operand (exponent field 0, fraction nonzero) gives 0 with `inexact_o`=1, except for the negative unsigned case covered by R4.
- R9: `done_o` is high only in the cycle after a cycle with `start_i` high. Result and flags change only on a start edge and otherwise hold their values whatever the operand does.
- R10: While `rst` is high at a clock edge, result, flags and `done_o` all clear to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Starts a conversion of `operand_i` at this edge |
| unsigned_i | input | 1 | 1 selects unsigned result, 0 selects signed |
| operand_i | input | 32 | Single-precision operand |
| result_o | output | 32 | Registered integer result |
| invalid_o | output | 1 | Registered invalid flag |
| inexact_o | output | 1 | Registered inexact flag |
| done_o | output | 1 | One-cycle pulse marking fresh outputs |

## Verification
The checker watches these properties on every cycle:
- the handshake timing and the hold of outputs between starts;
- mutual exclusion of the two flags;
- the zero-and-invalid outcome for NaNs and for negative unsigned operands;
- saturation above the positive limits in both modes.

The exact truncated values, the inexact decision, the asymmetric negative boundary at -2^31, denormals, negative zero, and the reset state can only be shown by the bench. Its directed corner operands and a seeded random sweep of exponents around the integer range are compared against a bench-side arithmetic model.

// File: rtl/f2i_pkg.sv
package f2i_pkg;

  // Operand class produced by the field decoder
  typedef enum logic [2:0] {
    CLS_ZERO = 3'd0,
    CLS_SUB  = 3'd1,
    CLS_NORM = 3'd2,
    CLS_INF  = 3'd3,
    CLS_NAN  = 3'd4
  } f2i_cls_e;

endpackage

// File: rtl/f2i_classify.sv
module f2i_classify
  import f2i_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  parameter int INT_W = 32,
  localparam int DATA_W = 1 + EXP_W + MAN_W,
  localparam int SH_W = $clog2(INT_W)
) (
  input  logic [DATA_W-1:0] operand_i,
  output logic              sign_o,
  output f2i_cls_e          cls_o,
  output logic              below_one_o,
  output logic              too_big_o,
  output logic              at_top_o,
  output logic [SH_W-1:0]   shamt_o,
  output logic [MAN_W:0]    sig_o
);

  localparam int BIAS = (1 << (EXP_W - 1)) - 1;
  localparam logic [EXP_W-1:0] EXP_ONES = '1;
  localparam logic [EXP_W:0] LIM_ONE = (EXP_W+1)'(BIAS);
  localparam logic [EXP_W:0] LIM_TOP = (EXP_W+1)'(BIAS + INT_W - 1);
  localparam logic [EXP_W:0] LIM_BIG = (EXP_W+1)'(BIAS + INT_W);

  logic [EXP_W-1:0] exp_f;
  logic [MAN_W-1:0] man_f;
  logic [EXP_W:0]   exp_x;
  logic             man_nz;

  assign sign_o = operand_i[DATA_W-1];
  assign exp_f  = operand_i[DATA_W-2 -: EXP_W];
  assign man_f  = operand_i[MAN_W-1:0];
  assign exp_x  = {1'b0, exp_f};
  assign man_nz = |man_f;

  always_comb begin
    if (exp_f == EXP_ONES) begin
      cls_o = man_nz ? CLS_NAN : CLS_INF;
    end else if (exp_f == '0) begin
      cls_o = man_nz ? CLS_SUB : CLS_ZERO;
    end else begin
      cls_o = CLS_NORM;
    end
  end

  // magnitude ranges by unbiased exponent
  assign below_one_o = exp_x < LIM_ONE;
  assign at_top_o    = exp_x == LIM_TOP;
  assign too_big_o   = exp_x >= LIM_BIG;
  assign shamt_o     = SH_W'(exp_x - LIM_ONE);
  assign sig_o       = {1'b1, man_f};

endmodule

// File: rtl/f2i_align.sv
module f2i_align #(
  parameter int MAN_W = 23,
  parameter int INT_W = 32,
  localparam int SH_W = $clog2(INT_W),
  localparam int WIDE_W = MAN_W + INT_W
) (
  input  logic [MAN_W:0]    sig_i,
  input  logic [SH_W-1:0]   shamt_i,
  output logic [INT_W-1:0]  mag_o,
  output logic              sticky_o
);

  // binary point sits below bit MAN_W of the widened significand
  logic [WIDE_W-1:0] wide;

  assign wide     = WIDE_W'(sig_i) << shamt_i;
  assign mag_o    = wide[WIDE_W-1:MAN_W];
  assign sticky_o = |wide[MAN_W-1:0];

endmodule

// File: rtl/f2i_pack.sv
module f2i_pack
  import f2i_pkg::*;
#(
  parameter int INT_W = 32
) (
  input  logic             sign_i,
  input  f2i_cls_e         cls_i,
  input  logic             below_one_i,
  input  logic             too_big_i,
  input  logic             at_top_i,
  input  logic [INT_W-1:0] mag_i,
  input  logic             sticky_i,
  input  logic             uns_i,
  output logic [INT_W-1:0] res_o,
  output logic             invalid_o,
  output logic             inexact_o
);

  localparam logic [INT_W-1:0] S_MAX = {1'b0, {(INT_W-1){1'b1}}};
  localparam logic [INT_W-1:0] S_MIN = {1'b1, {(INT_W-1){1'b0}}};
  localparam logic [INT_W-1:0] U_MAX = '1;

  logic             neg_bad;
  logic             ovf;
  logic [INT_W-1:0] sat;

  assign neg_bad = uns_i && sign_i && (cls_i != CLS_ZERO) && (cls_i != CLS_NAN);
  assign sat     = uns_i ? U_MAX : (sign_i ? S_MIN : S_MAX);
  // at the top exponent only the exact negative minimum still fits
  assign ovf     = uns_i ? too_big_i
                         : (too_big_i || (at_top_i && (!sign_i || (|mag_i[INT_W-2:0]))));

  always_comb begin
    res_o     = '0;
    invalid_o = 1'b0;
    inexact_o = 1'b0;
    if (cls_i == CLS_NAN || neg_bad) begin
      invalid_o = 1'b1;
    end else begin
      unique case (cls_i)
        CLS_SUB:  inexact_o = 1'b1;
        CLS_INF: begin
          res_o     = sat;
          invalid_o = 1'b1;
        end
        CLS_NORM: begin
          if (below_one_i) begin
            inexact_o = 1'b1;
          end else if (ovf) begin
            res_o     = sat;
            invalid_o = 1'b1;
          end else begin
            res_o     = (sign_i && !uns_i) ? (~mag_i + 1'b1) : mag_i;
            inexact_o = sticky_i;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/f2i_trunc.sv
module f2i_trunc
  import f2i_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  parameter int INT_W = 32,
  localparam int DATA_W = 1 + EXP_W + MAN_W,
  localparam int SH_W = $clog2(INT_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              unsigned_i,
  input  logic [DATA_W-1:0] operand_i,
  output logic [INT_W-1:0]  result_o,
  output logic              invalid_o,
  output logic              inexact_o,
  output logic              done_o
);

  logic             sign;
  f2i_cls_e         cls;
  logic             below_one;
  logic             too_big;
  logic             at_top;
  logic [SH_W-1:0]  shamt;
  logic [MAN_W:0]   sig;
  logic [INT_W-1:0] mag;
  logic             sticky;
  logic [INT_W-1:0] res_c;
  logic             inv_c;
  logic             inx_c;

  f2i_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W), .INT_W(INT_W)) u_cls (
    .operand_i   (operand_i),
    .sign_o      (sign),
    .cls_o       (cls),
    .below_one_o (below_one),
    .too_big_o   (too_big),
    .at_top_o    (at_top),
    .shamt_o     (shamt),
    .sig_o       (sig)
  );

  f2i_align #(.MAN_W(MAN_W), .INT_W(INT_W)) u_align (
    .sig_i    (sig),
    .shamt_i  (shamt),
    .mag_o    (mag),
    .sticky_o (sticky)
  );

  f2i_pack #(.INT_W(INT_W)) u_pack (
    .sign_i      (sign),
    .cls_i       (cls),
    .below_one_i (below_one),
    .too_big_i   (too_big),
    .at_top_i    (at_top),
    .mag_i       (mag),
    .sticky_i    (sticky),
    .uns_i       (unsigned_i),
    .res_o       (res_c),
    .invalid_o   (inv_c),
    .inexact_o   (inx_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o  <= '0;
      invalid_o <= 1'b0;
      inexact_o <= 1'b0;
      done_o    <= 1'b0;
    end else begin
      done_o <= start_i;
      if (start_i) begin
        result_o  <= res_c;
        invalid_o <= inv_c;
        inexact_o <= inx_c;
      end
    end
  end

endmodule

// File: rtl/f2i_trunc_chk.sv
module f2i_trunc_chk #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  parameter int INT_W = 32,
  localparam int DATA_W = 1 + EXP_W + MAN_W
) (
  input logic              clk,
  input logic              rst,
  input logic              start_i,
  input logic              unsigned_i,
  input logic [DATA_W-1:0] operand_i,
  input logic [INT_W-1:0]  result_o,
  input logic              invalid_o,
  input logic              inexact_o,
  input logic              done_o
);

  localparam int BIAS = (1 << (EXP_W - 1)) - 1;
  localparam logic [EXP_W-1:0] EXP_ONES = '1;
  localparam logic [EXP_W-1:0] EXP_U_LIM = EXP_W'(BIAS + INT_W);
  localparam logic [EXP_W-1:0] EXP_S_LIM = EXP_W'(BIAS + INT_W - 1);
  localparam logic [INT_W-1:0] S_MAX = {1'b0, {(INT_W-1){1'b1}}};

  logic             op_sign;
  logic [EXP_W-1:0] op_exp;
  logic             op_nan;

  assign op_sign = operand_i[DATA_W-1];
  assign op_exp  = operand_i[DATA_W-2 -: EXP_W];
  assign op_nan  = (op_exp == EXP_ONES) && (|operand_i[MAN_W-1:0]);

  p_done_after_start_r9: assert property (@(posedge clk) disable iff (rst)
    start_i |=> done_o);

  p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
    !start_i |=> !done_o);

  p_hold_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !start_i |=> ($stable(result_o) && $stable(invalid_o) && $stable(inexact_o)));

  p_flags_exclusive_r3: assert property (@(posedge clk) disable iff (rst)
    !(invalid_o && inexact_o));

  p_nan_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (start_i && op_nan) |=> (result_o == '0 && invalid_o && !inexact_o));

  p_uns_negative_r4: assert property (@(posedge clk) disable iff (rst)
    (start_i && unsigned_i && op_sign && !op_nan && (|operand_i[DATA_W-2:0]))
      |=> (result_o == '0 && invalid_o && !inexact_o));

  p_uns_saturate_r6: assert property (@(posedge clk) disable iff (rst)
    (start_i && unsigned_i && !op_sign && !op_nan && op_exp >= EXP_U_LIM)
      |=> (result_o == '1 && invalid_o));

  p_sgn_saturate_r5: assert property (@(posedge clk) disable iff (rst)
    (start_i && !unsigned_i && !op_sign && !op_nan && op_exp >= EXP_S_LIM)
      |=> (result_o == S_MAX && invalid_o));

endmodule

bind f2i_trunc f2i_trunc_chk #(.EXP_W(EXP_W), .MAN_W(MAN_W), .INT_W(INT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .start_i    (start_i),
  .unsigned_i (unsigned_i),
  .operand_i  (operand_i),
  .result_o   (result_o),
  .invalid_o  (invalid_o),
  .inexact_o  (inexact_o),
  .done_o     (done_o)
);

// File: tb/f2i_trunc_test.sv
`timescale 1ns/1ps
module f2i_trunc_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic        unsigned_i = 1'b0;
  logic [31:0] operand_i = '0;
  logic [31:0] result_o;
  logic        invalid_o;
  logic        inexact_o;
  logic        done_o;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  f2i_trunc uut (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .unsigned_i (unsigned_i),
    .operand_i  (operand_i),
    .result_o   (result_o),
    .invalid_o  (invalid_o),
    .inexact_o  (inexact_o),
    .done_o     (done_o)
  );

  // arithmetic reference: {result, invalid, inexact}
  function automatic logic [33:0] model(input logic [31:0] op, input logic uns);
    logic   s;
    int     ex;
    longint sig, mag, val;
    logic   fr, big;
    s  = op[31];
    ex = int'(op[30:23]);
    if (ex == 255 && op[22:0] != 0) return {32'h0, 2'b10};
    if (uns && s && op[30:0] != 0) return {32'h0, 2'b10};
    if (ex == 0) return {32'h0, 1'b0, op[22:0] != 0};
    if (ex == 255) return {uns ? 32'hFFFFFFFF : (s ? 32'h80000000 : 32'h7FFFFFFF), 2'b10};
    sig = longint'({1'b1, op[22:0]});
    ex  = ex - 127;
    big = 1'b0;
    fr  = 1'b0;
    mag = 0;
    if (ex >= 40) big = 1'b1;
    else if (ex >= 23) mag = sig << (ex - 23);
    else begin
      mag = sig >> (23 - ex);
      fr  = (mag << (23 - ex)) != sig;
    end
    val = s ? -mag : mag;
    if (uns) begin
      if (big || val > 64'sd4294967295) return {32'hFFFFFFFF, 2'b10};
    end else begin
      if (big || val > 64'sd2147483647 || val < -64'sd2147483648)
        return {s ? 32'h80000000 : 32'h7FFFFFFF, 2'b10};
    end
    return {val[31:0], 1'b0, fr};
  endfunction

  task automatic check(input string req, input logic [31:0] got_r, input logic got_v,
                       input logic got_x, input logic [31:0] exp_r, input logic exp_v,
                       input logic exp_x);
    checks++;
    if (got_r !== exp_r || got_v !== exp_v || got_x !== exp_x) begin
      errors++;
      $display("FAIL %s: got res=%h inv=%b inx=%b expected res=%h inv=%b inx=%b",
               req, got_r, got_v, got_x, exp_r, exp_v, exp_x);
    end
  endtask

  // one conversion, then an idle cycle with a disturbed operand
  task automatic convert(input logic [31:0] op, input logic uns, input string req,
                         input logic [33:0] exp_v);
    logic [31:0] held;
    @(negedge clk);
    operand_i  = op;
    unsigned_i = uns;
    start_i    = 1'b1;
    @(negedge clk);
    start_i    = 1'b0;
    operand_i  = ~op;
    unsigned_i = ~uns;
    check({req, " (R9 done)"}, {31'h0, done_o}, 1'b0, 1'b0, 32'h1, 1'b0, 1'b0);
    check(req, result_o, invalid_o, inexact_o, exp_v[33:2], exp_v[1], exp_v[0]);
    held = result_o;
    @(negedge clk);
    check("R9 hold", result_o, done_o, 1'b0, held, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R10 reset", result_o, invalid_o, inexact_o, 32'h0, 1'b0, 1'b0);
    check("R10 reset done", {31'h0, done_o}, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0);
    rst = 1'b0;

    convert(32'h40300000, 1'b0, "R1 R7 2.75",        {32'h00000002, 2'b01});
    convert(32'hC0300000, 1'b0, "R1 -2.75",          {32'hFFFFFFFE, 2'b01});
    convert(32'h3F000000, 1'b0, "R1 0.5",            {32'h00000000, 2'b01});
    convert(32'h3F800000, 1'b1, "R7 exact 1.0",      {32'h00000001, 2'b00});
    convert(32'h7FC00000, 1'b0, "R2 qnan",           {32'h00000000, 2'b10});
    convert(32'hFF800001, 1'b1, "R2 neg nan uns",    {32'h00000000, 2'b10});
    convert(32'hBFC00000, 1'b1, "R4 R3 -1.5 uns",    {32'h00000000, 2'b10});
    convert(32'hBE800000, 1'b1, "R4 -0.25 uns",      {32'h00000000, 2'b10});
    convert(32'hFF800000, 1'b1, "R4 -inf uns",       {32'h00000000, 2'b10});
    convert(32'h80400000, 1'b1, "R4 neg denorm uns", {32'h00000000, 2'b10});
    convert(32'h80000000, 1'b1, "R4 -0 uns",         {32'h00000000, 2'b00});
    convert(32'h4F000000, 1'b0, "R5 2^31",           {32'h7FFFFFFF, 2'b10});
    convert(32'hCF000000, 1'b0, "R5 -2^31",          {32'h80000000, 2'b00});
    convert(32'hCF000001, 1'b0, "R5 below -2^31",    {32'h80000000, 2'b10});
    convert(32'h7F800000, 1'b0, "R5 +inf",           {32'h7FFFFFFF, 2'b10});
    convert(32'h4EFFFFFF, 1'b0, "R5 max in range",   {32'h7FFFFF80, 2'b00});
    convert(32'h4F000000, 1'b1, "R6 2^31 uns",       {32'h80000000, 2'b00});
    convert(32'h4F7FFFFF, 1'b1, "R6 max in range",   {32'hFFFFFF00, 2'b00});
    convert(32'h4F800000, 1'b1, "R6 2^32",           {32'hFFFFFFFF, 2'b10});
    convert(32'h7F800000, 1'b1, "R6 +inf",           {32'hFFFFFFFF, 2'b10});
    convert(32'h00000001, 1'b0, "R8 tiny denorm",    {32'h00000000, 2'b01});
    convert(32'h80400000, 1'b0, "R8 neg denorm",     {32'h00000000, 2'b01});
    convert(32'h00400000, 1'b1, "R8 denorm uns",     {32'h00000000, 2'b01});

    void'($urandom(32'd20240611));
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] op;
      logic        uns;
      op  = $urandom;
      uns = op[0] ^ op[9];
      if (i % 4 != 0) op[30:23] = 8'(100 + ($urandom % 70));
      convert(op, uns, "R1 R7 random", model(op, uns));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule